// File: doc/BRIEF.md
# Lockable GPIO Control Register Bank

This block is the software-visible control store for one 32-pin general-purpose I/O port. It keeps the per-pin configuration words: drive value, drive enable, inversion, open-drain select, weak pull-up, weak pull-down, input gating, event mode, dual-edge select, event mask and sticky event flags. It presents each of them as a parallel output to the pad-resolution and event-detection logic, which are separate blocks. The resolved pin levels come back on `pad_din` and can be read on the bus. Per-pin event pulses from the detector arrive on `evt_hit` and are latched here.

The three registers that software most often changes one bit at a time are the drive value, the drive enable and the event mask. Each of them has a set alias and a clear alias, so that software can change single bits without a read-modify-write. A temporary write lock guards the configuration against stray stores. Any store to either lock word engages it. Only a two-word key, given in a fixed order, releases it.

The register bus is a plain synchronous port. It has no valid/ready pair and no back-pressure: a store presented with `bus_we` high completes at the next rising clock edge. Read data is combinational from `bus_addr` and is valid in the same cycle.

Top module: `gpio_lockreg`

## Requirements
- R1: After reset the lock is released (lock word reads 0, `o_locked` low), the pull-up and input-enable registers hold 0xFFFFFFFF, and every other register and output holds 0.
- R2: While the lock is released, a store of any value to offset 0x00 or offset 0x7C engages the lock. Offset 0x00 then reads 1, and it reads 0 while the lock is released.
- R3: The lock is released only by storing 0xC0DE1248 to offset 0x7C and then, as the very next store, 0xC0DEFA73 to offset 0x00. After release, configuration stores take effect again.
- R4: A store to offset 0x00 that is not immediately preceded by the correct 0x7C key leaves the lock engaged and disarms the key. Any other store placed between the two key words also disarms it.
- R5: While the lock is engaged, stores to every configuration register and to every set/clear alias are dropped, and the old values are kept.
- R6: A store to a set alias ORs the write data into its register. A store to a clear alias clears the register bits where the write data is 1. The alias pairs (set, clear) are: drive value 0x68/0x6C, drive enable 0x70/0x74, event mask 0x44/0x48.
- R7: Each `evt_hit` bit sets the matching event-status bit (offset 0x4C), and the bit stays set after the pulse. A store to 0x4C clears the bits where the data is 1, and this works even while the lock is engaged. When a hit and a clear reach the same bit in the same cycle, the hit wins.
- R8: Each register reads back at its own offset: inversion 0x08, drive value 0x0C, drive enable 0x10, open-drain 0x14, pull-up 0x1C, pull-down 0x20, event mode 0x28, dual-edge 0x2C, event mask 0x40, input-enable 0x58. Offset 0x04 returns `pad_din`, and stores to it have no effect. Alias, unmapped and 0x7C addresses read 0.
- R9: A store becomes visible on the register outputs at the rising edge that accepts it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 7 | Byte address of the access |
| bus_we | input | 1 | Store strobe, one cycle per store |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_din | input | 32 | Resolved pin levels from the pad logic |
| evt_hit | input | 32 | Per-pin event pulses from the detector |
| o_pol | output | 32 | Inversion per pin |
| o_dout | output | 32 | Drive value per pin |
| o_oe | output | 32 | Drive enable per pin |
| o_otyp | output | 32 | Open-drain select per pin |
| o_pu | output | 32 | Weak pull-up per pin |
| o_pd | output | 32 | Weak pull-down per pin |
| o_iem | output | 32 | Input gating per pin |
| o_evtyp | output | 32 | Event mode (edge when 1) per pin |
| o_evbe | output | 32 | Dual-edge select per pin |
| o_even | output | 32 | Event mask per pin |
| o_evst | output | 32 | Sticky event flags |
| o_locked | output | 1 | Lock engaged |

## Verification
The bench attacks the key sequence from several sides. It sends the second key word without the first, and it sends both key words with an unrelated store between them. A design that kept the key armed across other traffic, or that accepted the second word alone, would read 0 at offset 0x00 where 1 is expected. While locked, the bench pushes stores through the aliases as well as the base addresses, which exposes a lock that gates only the base registers. It also sends a hit and a status clear to the same bit in the same cycle: a design where the clear wins would lose the event. Finally, it reads the drive value one moment before the accepting edge, which catches a register that is bypassed combinationally.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  // byte offsets that software and the neighbouring blocks depend on
  localparam int unsigned OFS_LOCK_A  = 'h00;
  localparam int unsigned OFS_PIN_IN  = 'h04;
  localparam int unsigned OFS_INV     = 'h08;
  localparam int unsigned OFS_DRV     = 'h0C;
  localparam int unsigned OFS_DEN     = 'h10;
  localparam int unsigned OFS_ODRN    = 'h14;
  localparam int unsigned OFS_WPU     = 'h1C;
  localparam int unsigned OFS_WPD     = 'h20;
  localparam int unsigned OFS_EMODE   = 'h28;
  localparam int unsigned OFS_EDUAL   = 'h2C;
  localparam int unsigned OFS_EMSK    = 'h40;
  localparam int unsigned OFS_EMSK_S  = 'h44;
  localparam int unsigned OFS_EMSK_C  = 'h48;
  localparam int unsigned OFS_EFLG    = 'h4C;
  localparam int unsigned OFS_INGATE  = 'h58;
  localparam int unsigned OFS_DRV_S   = 'h68;
  localparam int unsigned OFS_DRV_C   = 'h6C;
  localparam int unsigned OFS_DEN_S   = 'h70;
  localparam int unsigned OFS_DEN_C   = 'h74;
  localparam int unsigned OFS_LOCK_B  = 'h7C;

  // release key, first word to OFS_LOCK_B, second to OFS_LOCK_A
  localparam logic [31:0] KEY_FIRST  = 32'hC0DE_1248;
  localparam logic [31:0] KEY_SECOND = 32'hC0DE_FA73;

  typedef enum logic [1:0] {
    LK_OPEN  = 2'd0,
    LK_SHUT  = 2'd1,
    LK_ARMED = 2'd2
  } lock_st_e;
endpackage

// File: rtl/gpr_lock.sv
module gpr_lock
  import gpr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic          wr_other,
  input  logic [DW-1:0] wdata,
  output logic          locked
);
  lock_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LK_OPEN:  if (wr_a || wr_b) st_d = LK_SHUT;
      LK_SHUT:  if (wr_b && wdata == KEY_FIRST) st_d = LK_ARMED;
      LK_ARMED: begin
        if (wr_a)          st_d = (wdata == KEY_SECOND) ? LK_OPEN : LK_SHUT;
        else if (wr_b)     st_d = (wdata == KEY_FIRST) ? LK_ARMED : LK_SHUT;
        else if (wr_other) st_d = LK_SHUT;
      end
      default:  st_d = LK_SHUT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= LK_OPEN;
    else        st_q <= st_d;
  end

  assign locked = (st_q != LK_OPEN);

  p_engage_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && (wr_a || wr_b)) |=> locked);

  p_release_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(wr_a && wdata == KEY_SECOND));

  p_bad_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_a && wdata != KEY_SECOND) |=> locked);

  p_other_disarms_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_other) |=> ##1 (locked || $past(wr_a)));
endmodule

// File: rtl/gpr_field.sv
module gpr_field #(
  parameter int          DW      = 32,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock_i,
  input  logic          wr_base,
  input  logic          wr_set,
  input  logic          wr_clr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)             q <= RST_VAL;
    else if (!lock_i) begin
      if (wr_base)          q <= wdata;
      else if (wr_set)      q <= q | wdata;
      else if (wr_clr)      q <= q & ~wdata;
    end
  end

  p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> $stable(q));

  p_set_or_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_i && wr_set && !wr_base) |=> q == ($past(q) | $past(wdata)));

  p_clr_andn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_i && wr_clr && !wr_base && !wr_set) |=> q == ($past(q) & ~$past(wdata)));
endmodule

// File: rtl/gpr_evflag.sv
module gpr_evflag #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] hit,
  input  logic          wr_clr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (hit[i]) q[i] <= 1'b1;
      else if (wr_clr && wdata[i]) q[i] <= 1'b0;
    end
  end

  p_hit_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & $past(hit)) == $past(hit)));

  p_hold_no_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_clr |=> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/gpio_lockreg.sv
module gpio_lockreg
  import gpr_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] pad_din,
  input  logic [DW-1:0] evt_hit,
  output logic [DW-1:0] o_pol,
  output logic [DW-1:0] o_dout,
  output logic [DW-1:0] o_oe,
  output logic [DW-1:0] o_otyp,
  output logic [DW-1:0] o_pu,
  output logic [DW-1:0] o_pd,
  output logic [DW-1:0] o_iem,
  output logic [DW-1:0] o_evtyp,
  output logic [DW-1:0] o_evbe,
  output logic [DW-1:0] o_even,
  output logic [DW-1:0] o_evst,
  output logic          o_locked
);
  localparam logic [DW-1:0] ALL_ONES = '1;

  function automatic logic hit_at(input logic [AW-1:0] a, input int unsigned ofs);
    return a == AW'(ofs);
  endfunction

  logic wr_la, wr_lb, wr_other, locked;
  assign wr_la    = bus_we && hit_at(bus_addr, OFS_LOCK_A);
  assign wr_lb    = bus_we && hit_at(bus_addr, OFS_LOCK_B);
  assign wr_other = bus_we && !wr_la && !wr_lb;

  gpr_lock #(.DW(DW)) u_lock (
    .clk(clk), .rst_n(rst_n), .wr_a(wr_la), .wr_b(wr_lb),
    .wr_other(wr_other), .wdata(bus_wdata), .locked(locked)
  );

  function automatic logic wr_at(input logic we, input logic [AW-1:0] a,
                                 input int unsigned ofs);
    return we && (a == AW'(ofs));
  endfunction

  // registers with set/clear aliases
  gpr_field #(.DW(DW), .RST_VAL('0)) u_drv (
    .clk(clk), .rst_n(rst_n), .lock_i(locked),
    .wr_base(wr_at(bus_we, bus_addr, OFS_DRV)),
    .wr_set (wr_at(bus_we, bus_addr, OFS_DRV_S)),
    .wr_clr (wr_at(bus_we, bus_addr, OFS_DRV_C)),
    .wdata(bus_wdata), .q(o_dout));

  gpr_field #(.DW(DW), .RST_VAL('0)) u_den (
    .clk(clk), .rst_n(rst_n), .lock_i(locked),
    .wr_base(wr_at(bus_we, bus_addr, OFS_DEN)),
    .wr_set (wr_at(bus_we, bus_addr, OFS_DEN_S)),
    .wr_clr (wr_at(bus_we, bus_addr, OFS_DEN_C)),
    .wdata(bus_wdata), .q(o_oe));

  gpr_field #(.DW(DW), .RST_VAL('0)) u_emsk (
    .clk(clk), .rst_n(rst_n), .lock_i(locked),
    .wr_base(wr_at(bus_we, bus_addr, OFS_EMSK)),
    .wr_set (wr_at(bus_we, bus_addr, OFS_EMSK_S)),
    .wr_clr (wr_at(bus_we, bus_addr, OFS_EMSK_C)),
    .wdata(bus_wdata), .q(o_even));

  // plain registers
  gpr_field #(.DW(DW), .RST_VAL('0)) u_inv (
    .clk(clk), .rst_n(rst_n), .lock_i(locked),
    .wr_base(wr_at(bus_we, bus_addr, OFS_INV)), .wr_set(1'b0), .wr_clr(1'b0),
    .wdata(bus_wdata), .q(o_pol));

  gpr_field #(.DW(DW), .RST_VAL('0)) u_odrn (
    .clk(clk), .rst_n(rst_n), .lock_i(locked),
    .wr_base(wr_at(bus_we, bus_addr, OFS_ODRN)), .wr_set(1'b0), .wr_clr(1'b0),
    .wdata(bus_wdata), .q(o_otyp));

  gpr_field #(.DW(DW), .RST_VAL(ALL_ONES)) u_wpu (
    .clk(clk), .rst_n(rst_n), .lock_i(locked),
    .wr_base(wr_at(bus_we, bus_addr, OFS_WPU)), .wr_set(1'b0), .wr_clr(1'b0),
    .wdata(bus_wdata), .q(o_pu));

  gpr_field #(.DW(DW), .RST_VAL('0)) u_wpd (
    .clk(clk), .rst_n(rst_n), .lock_i(locked),
    .wr_base(wr_at(bus_we, bus_addr, OFS_WPD)), .wr_set(1'b0), .wr_clr(1'b0),
    .wdata(bus_wdata), .q(o_pd));

  gpr_field #(.DW(DW), .RST_VAL(ALL_ONES)) u_ingate (
    .clk(clk), .rst_n(rst_n), .lock_i(locked),
    .wr_base(wr_at(bus_we, bus_addr, OFS_INGATE)), .wr_set(1'b0), .wr_clr(1'b0),
    .wdata(bus_wdata), .q(o_iem));

  gpr_field #(.DW(DW), .RST_VAL('0)) u_emode (
    .clk(clk), .rst_n(rst_n), .lock_i(locked),
    .wr_base(wr_at(bus_we, bus_addr, OFS_EMODE)), .wr_set(1'b0), .wr_clr(1'b0),
    .wdata(bus_wdata), .q(o_evtyp));

  gpr_field #(.DW(DW), .RST_VAL('0)) u_edual (
    .clk(clk), .rst_n(rst_n), .lock_i(locked),
    .wr_base(wr_at(bus_we, bus_addr, OFS_EDUAL)), .wr_set(1'b0), .wr_clr(1'b0),
    .wdata(bus_wdata), .q(o_evbe));

  // sticky event flags, clear accepted regardless of the lock
  gpr_evflag #(.DW(DW)) u_eflg (
    .clk(clk), .rst_n(rst_n), .hit(evt_hit),
    .wr_clr(wr_at(bus_we, bus_addr, OFS_EFLG)),
    .wdata(bus_wdata), .q(o_evst));

  assign o_locked = locked;

  always_comb begin
    bus_rdata = '0;
    if      (hit_at(bus_addr, OFS_LOCK_A)) bus_rdata = {{(DW-1){1'b0}}, locked};
    else if (hit_at(bus_addr, OFS_PIN_IN)) bus_rdata = pad_din;
    else if (hit_at(bus_addr, OFS_INV))    bus_rdata = o_pol;
    else if (hit_at(bus_addr, OFS_DRV))    bus_rdata = o_dout;
    else if (hit_at(bus_addr, OFS_DEN))    bus_rdata = o_oe;
    else if (hit_at(bus_addr, OFS_ODRN))   bus_rdata = o_otyp;
    else if (hit_at(bus_addr, OFS_WPU))    bus_rdata = o_pu;
    else if (hit_at(bus_addr, OFS_WPD))    bus_rdata = o_pd;
    else if (hit_at(bus_addr, OFS_EMODE))  bus_rdata = o_evtyp;
    else if (hit_at(bus_addr, OFS_EDUAL))  bus_rdata = o_evbe;
    else if (hit_at(bus_addr, OFS_EMSK))   bus_rdata = o_even;
    else if (hit_at(bus_addr, OFS_EFLG))   bus_rdata = o_evst;
    else if (hit_at(bus_addr, OFS_INGATE)) bus_rdata = o_iem;
  end

  p_reset_open_r1: assert property (@(posedge clk)
    !rst_n |=> (!o_locked && o_pu == ALL_ONES && o_iem == ALL_ONES && o_dout == '0));

  p_no_early_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we) |=> $stable(o_dout) && $stable(o_oe) && $stable(o_pol));
endmodule

// File: tb/gpio_lockreg_test.sv
`timescale 1ns/1ps
module gpio_lockreg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_din = 32'hA5A5_0F0F;
  logic [31:0] evt_hit = '0;
  logic [31:0] o_pol, o_dout, o_oe, o_otyp, o_pu, o_pd, o_iem;
  logic [31:0] o_evtyp, o_evbe, o_even, o_evst;
  logic        o_locked;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_lockreg uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_din(pad_din),
    .evt_hit(evt_hit), .o_pol(o_pol), .o_dout(o_dout), .o_oe(o_oe),
    .o_otyp(o_otyp), .o_pu(o_pu), .o_pd(o_pd), .o_iem(o_iem),
    .o_evtyp(o_evtyp), .o_evbe(o_evbe), .o_even(o_even), .o_evst(o_evst),
    .o_locked(o_locked)
  );

  typedef struct packed {
    logic [6:0]  wa;
    logic [31:0] wd;
    logic [6:0]  ra;
    logic [31:0] ex;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{7'h10, 32'h3456789A, 7'h10, 32'h3456789A, 8'd8},  // R8
    '{7'h74, 32'h00030002, 7'h10, 32'h34547898, 8'd6},  // R6 clear
    '{7'h70, 32'h0000F001, 7'h10, 32'h3454F899, 8'd6},  // R6 set
    '{7'h0C, 32'h12345678, 7'h0C, 32'h12345678, 8'd8},
    '{7'h68, 32'h0000000F, 7'h0C, 32'h1234567F, 8'd6},
    '{7'h6C, 32'h12000000, 7'h0C, 32'h0034567F, 8'd6},
    '{7'h40, 32'hFFFF0000, 7'h40, 32'hFFFF0000, 8'd8},
    '{7'h44, 32'h000000FF, 7'h40, 32'hFFFF00FF, 8'd6},
    '{7'h48, 32'h0F00000F, 7'h40, 32'hF0FF00F0, 8'd6},
    '{7'h08, 32'h6789ABCD, 7'h08, 32'h6789ABCD, 8'd8},
    '{7'h1C, 32'h789ABCDE, 7'h1C, 32'h789ABCDE, 8'd8},
    '{7'h20, 32'h00FF00FF, 7'h20, 32'h00FF00FF, 8'd8},
    '{7'h14, 32'h456789AB, 7'h14, 32'h456789AB, 8'd8},
    '{7'h28, 32'hFFFFFFFF, 7'h28, 32'hFFFFFFFF, 8'd8},
    '{7'h2C, 32'h0000FFFF, 7'h2C, 32'h0000FFFF, 8'd8},
    '{7'h58, 32'h87654321, 7'h58, 32'h87654321, 8'd8},
    '{7'h04, 32'hFFFFFFFF, 7'h04, 32'hA5A50F0F, 8'd8},  // R8 pin input read-only
    '{7'h64, 32'hFFFFFFFF, 7'h68, 32'h00000000, 8'd8},  // R8 alias reads 0
    '{7'h60, 32'hFFFFFFFF, 7'h64, 32'h00000000, 8'd8}   // R8 unmapped reads 0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(7'h00, v); chk("R1 lock word", v, 32'h0);
    chk("R1 o_locked", {31'b0, o_locked}, 32'h0);
    rd(7'h1C, v); chk("R1 pull-up", v, 32'hFFFFFFFF);
    rd(7'h58, v); chk("R1 input-enable", v, 32'hFFFFFFFF);
    chk("R1 drive", o_dout, 32'h0);
    chk("R1 enable", o_oe, 32'h0);
    chk("R1 flags", o_evst, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(TBL[i].wa, TBL[i].wd);
      rd(TBL[i].ra, v);
      chk($sformatf("R%0d vector %0d", TBL[i].req, i), v, TBL[i].ex);
    end
    chk("R9 o_oe port", o_oe, 32'h3454F899);

    // R2 engage via first lock word
    wr(7'h00, 32'h0);
    rd(7'h00, v); chk("R2 locked reads 1", v, 32'h1);
    // R5 base and alias stores dropped
    wr(7'h0C, 32'hA9876543);
    rd(7'h0C, v); chk("R5 drive kept", v, 32'h0034567F);
    wr(7'h70, 32'hFFFFFFFF);
    rd(7'h10, v); chk("R5 set alias dropped", v, 32'h3454F899);
    wr(7'h48, 32'hFFFFFFFF);
    rd(7'h40, v); chk("R5 clear alias dropped", v, 32'hF0FF00F0);
    wr(7'h1C, 32'h0);
    rd(7'h1C, v); chk("R5 pull-up kept", v, 32'h789ABCDE);

    // R4 second word alone
    wr(7'h00, 32'hC0DEFA73);
    rd(7'h00, v); chk("R4 second word alone", v, 32'h1);
    // R4 intervening store disarms
    wr(7'h7C, 32'hC0DE1248);
    wr(7'h0C, 32'h00000001);
    wr(7'h00, 32'hC0DEFA73);
    rd(7'h00, v); chk("R4 interrupted key", v, 32'h1);
    // R3 correct key
    wr(7'h7C, 32'hC0DE1248);
    wr(7'h00, 32'hC0DEFA73);
    rd(7'h00, v); chk("R3 released", v, 32'h0);
    wr(7'h0C, 32'hA9876543);
    rd(7'h0C, v); chk("R3 store accepted", v, 32'hA9876543);

    // R9 not visible before the accepting edge
    @(negedge clk);
    bus_addr = 7'h0C; bus_we = 1'b1; bus_wdata = 32'h55AA_33CC;
    #1 chk("R9 before edge", o_dout, 32'hA9876543);
    @(negedge clk);
    bus_we = 1'b0;
    chk("R9 after edge", o_dout, 32'h55AA33CC);

    // R7 sticky flags
    @(negedge clk); evt_hit = 32'h00008001;
    @(negedge clk); evt_hit = '0;
    @(negedge clk);
    rd(7'h4C, v); chk("R7 sticky", v, 32'h00008001);
    // R2 engage via second lock word, then clear while locked
    wr(7'h7C, 32'h0);
    rd(7'h00, v); chk("R2 engage via 0x7C", v, 32'h1);
    wr(7'h4C, 32'h00000001);
    rd(7'h4C, v); chk("R7 clear while locked", v, 32'h00008000);
    // R7 hit wins over same-cycle clear
    @(negedge clk);
    evt_hit = 32'h00000010;
    bus_addr = 7'h4C; bus_we = 1'b1; bus_wdata = 32'h00008010;
    @(negedge clk);
    evt_hit = '0; bus_we = 1'b0;
    chk("R7 hit beats clear", o_evst, 32'h00000010);

    finish_run();
  end
endmodule